// File: doc/BRIEF.md
# I2C Target Receive Queue with Transaction Framing

This block sits behind the byte engine of an I2C target. It takes address-phase, data-byte, stop and transmit-empty events from that engine and turns each master write addressed to this target into a run of tagged queue entries: an opening entry carrying the address byte, a middle entry for every byte but the last, and a closing entry for the last byte. Software pops one 32-bit word at a time and can rebuild transaction boundaries from the tags alone, with no extra status reads.

A 7-bit own address with an enable bit decides which bus traffic belongs to this target. Six sticky interrupt flags report queue fill, queue threshold, arrival of new entries, the end of a master read, transmit-empty during a master read, and the case where a write phase is followed by a repeated-start read of this target. Flags are cleared by writing ones to a clear word whose bit positions match the flag word. A flush control empties the queue.

Top module: `i2c_tgt_rxq`

## Requirements
- R1: After reset the queue is empty (rx_level 0), pop_word is 0, flag_word is 0 and the own-address register reads 0.
- R2: The own-address register holds the address in bits 6:0 and an enable in bit 7; an address phase matches only when the enable is 1 and the address is equal. An unmatched or disabled address creates no entries, and writing 0 turns matching off.
- R3: A popped word has the data byte in bits 7:0, the tag in bits 31:30 and zeros elsewhere. Tags: 0 empty, 1 start of write, 2 write data, 3 last byte of write. A start entry carries the address byte as seen on the wire ({address, 0}).
- R4: Within a matched write every byte except the last is queued with tag 2 and the last with tag 3. A byte is held back until the next byte, a stop or a new address phase reveals whether it is the last, so after a start and k>=1 bytes the level is k. A write with no data bytes closes with a tag-3 entry holding 0.
- R5: An address phase that interrupts a matched write closes it (tag 3) and, if it is a new matched write, opens the next one in the same cycle, with the close ordered before the open.
- R6: Popping returns the oldest entry first and removes it; popping an empty queue returns 0 and changes nothing.
- R7: The queue holds 64 entries; entries arriving when full are dropped. Flag bit 26 is set while full or after a drop, cannot be cleared while the queue is still full, clears by write-1 once below full, and is cleared by a flush.
- R8: Flag bit 24 sets when an entry is accepted, clears by write-1, and clears by itself when the queue becomes empty.
- R9: Flag bit 25 sets while the level is at least the nonzero threshold input, and a write-1 only clears it when the level is below the threshold. A threshold of 0 disables it.
- R10: Flag bit 21 sets when a matched read address phase directly follows a matched write phase; a read that does not follow a write leaves it clear.
- R11: During a matched read, transmit-empty from the engine sets flag bit 22 and a stop sets flag bit 23; transmit-empty outside a matched read has no effect.
- R12: A flush empties the queue in the next cycle and wins over entries pushed in the same cycle; the byte held back for an open write is kept.
- R13: Entries are visible on pop_word and rx_level, and flags on flag_word, in the cycle after the clock edge that captured the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| own_addr_we | input | 1 | Write strobe for the own-address register |
| own_addr_wdata | input | 8 | New own address (6:0) and enable (7) |
| own_addr_q | output | 8 | Current own-address register |
| rx_thld | input | 7 | Threshold level for flag bit 25, 0 disables |
| rx_flush | input | 1 | Empty the queue |
| pop | input | 1 | Remove the head entry at this clock edge |
| pop_word | output | 32 | Head entry: tag in 31:30, data in 7:0 |
| rx_level | output | 7 | Number of queued entries |
| flag_word | output | 32 | Interrupt flags in bits 26:21 |
| flag_clr | input | 32 | Write-1-to-clear mask, same positions as flag_word |
| eng_addr_vld | input | 1 | Engine reports an address phase |
| eng_addr | input | 7 | Address of that phase |
| eng_rw | input | 1 | 1 for a master read, 0 for a master write |
| eng_byte_vld | input | 1 | Engine reports a received write byte |
| eng_byte | input | 8 | The received byte |
| eng_stop | input | 1 | Engine reports a stop condition |
| eng_tx_empty | input | 1 | Engine reports its transmit side ran empty |

## Verification
Every engine event is held for one clock and the edge that captures it also updates the queue and the flags, so its result is due one cycle later; the bench drives on the falling edge and reads the outputs on the next falling edge, half a cycle after that update. The held-back last byte adds one event of delay to data entries, and the bench counts that by checking the level after a known number of bytes before the stop arrives. Popped words are read on the falling edge where pop is raised, before the edge that removes them. Write lengths from zero to five bytes, a run past capacity, and read sequences with and without a preceding write are each compared against values the bench works out from the requirements.

// File: rtl/i2c_tgt_rxq_pkg.sv
package i2c_tgt_rxq_pkg;

    // Framing tag carried by every queue entry
    typedef enum logic [1:0] {
        TAG_NONE  = 2'd0,
        TAG_START = 2'd1,
        TAG_DATA  = 2'd2,
        TAG_END   = 2'd3
    } rxq_tag_e;

    typedef struct packed {
        rxq_tag_e    tag;
        logic [7:0]  data;
    } rxq_entry_t;

    // Events the framer reports toward the flag register
    typedef struct packed {
        logic rdreq;
        logic underrun;
        logic busy;
    } rxq_evt_t;

    // Flag indices inside the compact flag vector
    localparam int FLG_RDREQ    = 0;
    localparam int FLG_UNDERRUN = 1;
    localparam int FLG_BUSY     = 2;
    localparam int FLG_RXEVT    = 3;
    localparam int FLG_THLD     = 4;
    localparam int FLG_FULL     = 5;
    localparam int NUM_FLAGS    = 6;

    // Position of the flag vector inside the 32-bit flag word
    localparam int FLAG_LSB = 21;
    localparam int FLAG_MSB = FLAG_LSB + NUM_FLAGS - 1;

    function automatic logic [31:0] pack_word(rxq_entry_t e);
        logic [31:0] w;
        w        = '0;
        w[31:30] = e.tag;
        w[7:0]   = e.data;
        return w;
    endfunction

endpackage

// File: rtl/rxq_store.sv
// Entry storage with two write slots per cycle; DEPTH must be a power of two
module rxq_store
    import i2c_tgt_rxq_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push_a,
    input  rxq_entry_t    ent_a,
    input  logic          push_b,
    input  rxq_entry_t    ent_b,
    input  logic          pop,
    output rxq_entry_t    head,
    output logic [CW-1:0] level,
    output logic [CW-1:0] level_nxt,
    output logic          accepted,
    output logic          dropped
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    rxq_entry_t    mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt;
    logic          acc_a, acc_b, do_pop;

    always_comb begin
        acc_a    = push_a && !flush && (cnt < FULL_CNT);
        acc_b    = push_b && !flush &&
                   ((int'(cnt) + int'(acc_a)) < DEPTH);
        do_pop   = pop && !flush && (cnt != '0);
        accepted = acc_a || acc_b;
        dropped  = !flush && ((push_a && !acc_a) || (push_b && !acc_b));
        if (flush) begin
            level_nxt = '0;
        end else begin
            level_nxt = cnt + CW'(acc_a) + CW'(acc_b) - CW'(do_pop);
        end
        head = (cnt == '0) ? rxq_entry_t'('0) : mem[rd_ptr];
    end

    always_ff @(posedge clk) begin
        if (acc_a) begin
            mem[wr_ptr] <= ent_a;
        end
        if (acc_b) begin
            mem[AW'(wr_ptr + AW'(acc_a))] <= ent_b;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            wr_ptr <= wr_ptr + AW'(acc_a) + AW'(acc_b);
            rd_ptr <= rd_ptr + AW'(do_pop);
            cnt    <= level_nxt;
        end
    end

    assign level = cnt;

endmodule

// File: rtl/rxq_framer.sv
// Turns engine events into tagged entries and read-side events
module rxq_framer
    import i2c_tgt_rxq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  own_addr,
    input  logic        eng_addr_vld,
    input  logic [6:0]  eng_addr,
    input  logic        eng_rw,
    input  logic        eng_byte_vld,
    input  logic [7:0]  eng_byte,
    input  logic        eng_stop,
    input  logic        eng_tx_empty,
    output logic        push_a,
    output rxq_entry_t  ent_a,
    output logic        push_b,
    output rxq_entry_t  ent_b,
    output rxq_evt_t    evt
);

    logic       in_wr;     // matched write phase open
    logic       rd_act;    // matched read phase open
    logic       stg_vld;   // a held-back byte exists
    logic [7:0] stg_byte;

    logic       hit;
    rxq_entry_t close_ent, open_ent;

    always_comb begin
        hit       = own_addr[7] && (eng_addr == own_addr[6:0]);
        close_ent = '{tag: TAG_END,   data: (stg_vld ? stg_byte : 8'h00)};
        open_ent  = '{tag: TAG_START, data: {eng_addr, 1'b0}};
        push_a    = 1'b0;
        push_b    = 1'b0;
        ent_a     = '0;
        ent_b     = '0;
        evt       = '0;
        if (eng_addr_vld) begin
            if (in_wr) begin
                push_a = 1'b1;
                ent_a  = close_ent;
                if (hit && !eng_rw) begin
                    push_b = 1'b1;
                    ent_b  = open_ent;
                end
            end else if (hit && !eng_rw) begin
                push_a = 1'b1;
                ent_a  = open_ent;
            end
            evt.rdreq = hit && eng_rw && in_wr;
        end else if (eng_byte_vld) begin
            if (in_wr && stg_vld) begin
                push_a = 1'b1;
                ent_a  = '{tag: TAG_DATA, data: stg_byte};
            end
        end else if (eng_stop) begin
            if (in_wr) begin
                push_a = 1'b1;
                ent_a  = close_ent;
            end
            evt.busy = rd_act;
        end
        evt.underrun = eng_tx_empty && rd_act;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_wr    <= 1'b0;
            rd_act   <= 1'b0;
            stg_vld  <= 1'b0;
            stg_byte <= '0;
        end else if (eng_addr_vld) begin
            in_wr   <= hit && !eng_rw;
            rd_act  <= hit && eng_rw;
            stg_vld <= 1'b0;
        end else if (eng_byte_vld) begin
            if (in_wr) begin
                stg_byte <= eng_byte;
                stg_vld  <= 1'b1;
            end
        end else if (eng_stop) begin
            in_wr   <= 1'b0;
            rd_act  <= 1'b0;
            stg_vld <= 1'b0;
        end
    end

endmodule

// File: rtl/rxq_flags.sv
// Sticky write-1-to-clear interrupt flags
module rxq_flags
    import i2c_tgt_rxq_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 flush,
    input  rxq_evt_t             evt,
    input  logic                 accepted,
    input  logic                 dropped,
    input  logic [CW-1:0]        level_nxt,
    input  logic [CW-1:0]        rx_thld,
    input  logic [NUM_FLAGS-1:0] clr,
    output logic [NUM_FLAGS-1:0] flags
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [NUM_FLAGS-1:0] kept, nxt;

    always_comb begin
        kept                = flags & ~clr;
        nxt[FLG_RDREQ]      = kept[FLG_RDREQ]    | evt.rdreq;
        nxt[FLG_UNDERRUN]   = kept[FLG_UNDERRUN] | evt.underrun;
        nxt[FLG_BUSY]       = kept[FLG_BUSY]     | evt.busy;
        nxt[FLG_RXEVT]      = (kept[FLG_RXEVT] | accepted) && (level_nxt != '0);
        nxt[FLG_THLD]       = kept[FLG_THLD] |
                              ((rx_thld != '0) && (level_nxt >= rx_thld));
        nxt[FLG_FULL]       = !flush &&
                              (kept[FLG_FULL] | dropped | (level_nxt == FULL_CNT));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            flags <= nxt;
        end
    end

endmodule

// File: rtl/i2c_tgt_rxq.sv
module i2c_tgt_rxq
    import i2c_tgt_rxq_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          own_addr_we,
    input  logic [7:0]    own_addr_wdata,
    output logic [7:0]    own_addr_q,
    input  logic [CW-1:0] rx_thld,
    input  logic          rx_flush,
    input  logic          pop,
    output logic [31:0]   pop_word,
    output logic [CW-1:0] rx_level,
    output logic [31:0]   flag_word,
    input  logic [31:0]   flag_clr,
    input  logic          eng_addr_vld,
    input  logic [6:0]    eng_addr,
    input  logic          eng_rw,
    input  logic          eng_byte_vld,
    input  logic [7:0]    eng_byte,
    input  logic          eng_stop,
    input  logic          eng_tx_empty
);

    logic                 push_a, push_b, accepted, dropped;
    rxq_entry_t           ent_a, ent_b, head;
    rxq_evt_t             evt;
    logic [CW-1:0]        level_nxt;
    logic [NUM_FLAGS-1:0] flags;
    logic                 unused_clr;

    assign unused_clr = ^{flag_clr[31:FLAG_MSB+1], flag_clr[FLAG_LSB-1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            own_addr_q <= '0;
        end else if (own_addr_we) begin
            own_addr_q <= own_addr_wdata;
        end
    end

    rxq_framer u_framer (
        .clk          (clk),
        .rst          (rst),
        .own_addr     (own_addr_q),
        .eng_addr_vld (eng_addr_vld),
        .eng_addr     (eng_addr),
        .eng_rw       (eng_rw),
        .eng_byte_vld (eng_byte_vld),
        .eng_byte     (eng_byte),
        .eng_stop     (eng_stop),
        .eng_tx_empty (eng_tx_empty),
        .push_a       (push_a),
        .ent_a        (ent_a),
        .push_b       (push_b),
        .ent_b        (ent_b),
        .evt          (evt)
    );

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .flush     (rx_flush),
        .push_a    (push_a),
        .ent_a     (ent_a),
        .push_b    (push_b),
        .ent_b     (ent_b),
        .pop       (pop),
        .head      (head),
        .level     (rx_level),
        .level_nxt (level_nxt),
        .accepted  (accepted),
        .dropped   (dropped)
    );

    rxq_flags #(.DEPTH(DEPTH)) u_flags (
        .clk       (clk),
        .rst       (rst),
        .flush     (rx_flush),
        .evt       (evt),
        .accepted  (accepted),
        .dropped   (dropped),
        .level_nxt (level_nxt),
        .rx_thld   (rx_thld),
        .clr       (flag_clr[FLAG_MSB:FLAG_LSB]),
        .flags     (flags)
    );

    always_comb begin
        pop_word                    = pack_word(head);
        flag_word                   = '0;
        flag_word[FLAG_MSB:FLAG_LSB] = flags;
    end

endmodule

// File: rtl/i2c_tgt_rxq_chk.sv
module i2c_tgt_rxq_chk #(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst,
    input logic [CW-1:0] rx_level,
    input logic [31:0]   pop_word,
    input logic [31:0]   flag_word,
    input logic          rx_flush,
    input logic          eng_tx_empty
);

    assert_level_bound_R7: assert property (@(posedge clk) disable iff (rst)
        int'(rx_level) <= DEPTH);

    assert_full_flag_R7: assert property (@(posedge clk) disable iff (rst)
        (int'(rx_level) == DEPTH) |-> flag_word[26]);

    assert_empty_word_R6: assert property (@(posedge clk) disable iff (rst)
        (rx_level == '0) |-> (pop_word == 32'h0));

    assert_tag_present_R3: assert property (@(posedge clk) disable iff (rst)
        (rx_level != '0) |-> (pop_word[31:30] != 2'd0));

    assert_flush_empties_R12: assert property (@(posedge clk) disable iff (rst)
        rx_flush |=> (rx_level == '0));

    assert_rxevt_empty_R8: assert property (@(posedge clk) disable iff (rst)
        (rx_level == '0) |-> !flag_word[24]);

    assert_level_step_R5: assert property (@(posedge clk) disable iff (rst)
        !$past(rx_flush) |-> (int'(rx_level) <= int'($past(rx_level)) + 2));

    assert_underrun_cause_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_word[22]) |-> $past(eng_tx_empty));

endmodule

bind i2c_tgt_rxq i2c_tgt_rxq_chk #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .rx_level     (rx_level),
    .pop_word     (pop_word),
    .flag_word    (flag_word),
    .rx_flush     (rx_flush),
    .eng_tx_empty (eng_tx_empty)
);

// File: tb/test_i2c_tgt_rxq.sv
module test_i2c_tgt_rxq;

    localparam int DEPTH = 64;
    localparam int CW    = $clog2(DEPTH) + 1;
    localparam logic [6:0] ME    = 7'h2A;
    localparam logic [6:0] OTHER = 7'h2B;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          own_addr_we = 1'b0;
    logic [7:0]    own_addr_wdata = '0;
    logic [7:0]    own_addr_q;
    logic [CW-1:0] rx_thld = '0;
    logic          rx_flush = 1'b0;
    logic          pop = 1'b0;
    logic [31:0]   pop_word;
    logic [CW-1:0] rx_level;
    logic [31:0]   flag_word;
    logic [31:0]   flag_clr = '0;
    logic          eng_addr_vld = 1'b0;
    logic [6:0]    eng_addr = '0;
    logic          eng_rw = 1'b0;
    logic          eng_byte_vld = 1'b0;
    logic [7:0]    eng_byte = '0;
    logic          eng_stop = 1'b0;
    logic          eng_tx_empty = 1'b0;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    i2c_tgt_rxq #(.DEPTH(DEPTH)) i_i2c_tgt_rxq (.*);

    function automatic logic [31:0] word(int tag, int data);
        return (32'(tag) << 30) | 32'(data & 8'hFF);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic ev_addr(logic [6:0] a, logic rw);
        eng_addr_vld = 1'b1; eng_addr = a; eng_rw = rw;
        @(negedge clk);
        eng_addr_vld = 1'b0;
    endtask

    task automatic ev_byte(logic [7:0] b);
        eng_byte_vld = 1'b1; eng_byte = b;
        @(negedge clk);
        eng_byte_vld = 1'b0;
    endtask

    task automatic ev_stop();
        eng_stop = 1'b1;
        @(negedge clk);
        eng_stop = 1'b0;
    endtask

    task automatic ev_txe();
        eng_tx_empty = 1'b1;
        @(negedge clk);
        eng_tx_empty = 1'b0;
    endtask

    task automatic set_own(logic [7:0] v);
        own_addr_we = 1'b1; own_addr_wdata = v;
        @(negedge clk);
        own_addr_we = 1'b0;
    endtask

    task automatic clear(logic [31:0] m);
        flag_clr = m;
        @(negedge clk);
        flag_clr = '0;
    endtask

    task automatic pop_chk(string req, int tag, int data);
        check(req, pop_word, word(tag, data));
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
    endtask

    task automatic flush();
        rx_flush = 1'b1;
        @(negedge clk);
        rx_flush = 1'b0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 level", 32'(rx_level), 0);
        check("R1 word", pop_word, 0);
        check("R1 flags", flag_word, 0);
        check("R1 own", 32'(own_addr_q), 0);

        // R2 enable and address
        set_own({1'b1, ME});
        check("R2 own readback", 32'(own_addr_q), 32'h80 | 32'(ME));

        // R3/R4/R6/R8/R13 sweep of write lengths 0..5
        for (int n = 0; n <= 5; n++) begin
            ev_addr(ME, 1'b0);
            for (int i = 0; i < n; i++) begin
                ev_byte(8'(16 * n + i));
            end
            if (n == 3) check("R4 held-back byte", 32'(rx_level), 3);
            ev_stop();
            check("R13 level after stop", 32'(rx_level), 32'(1 + ((n == 0) ? 1 : n)));
            check("R8 rx event set", 32'(flag_word[24]), 1);
            pop_chk("R3 start entry", 1, {ME, 1'b0});
            if (n == 0) pop_chk("R4 empty write close", 3, 0);
            for (int i = 0; i < n; i++) begin
                pop_chk("R4 write entry", (i == n - 1) ? 3 : 2, 16 * n + i);
            end
            check("R6 drained", 32'(rx_level), 0);
            check("R8 rx event auto clear", 32'(flag_word[24]), 0);
        end

        // R2 foreign address and disabled matching
        ev_addr(OTHER, 1'b0); ev_byte(8'h77); ev_stop();
        check("R2 foreign address", 32'(rx_level), 0);
        set_own({1'b0, ME});
        ev_addr(ME, 1'b0); ev_byte(8'h66); ev_stop();
        check("R2 disabled", 32'(rx_level), 0);
        set_own(8'h00);
        ev_addr(7'h00, 1'b0); ev_byte(8'h55); ev_stop();
        check("R2 zero disables", 32'(rx_level), 0);
        set_own({1'b1, ME});

        // R6 pop on empty
        pop_chk("R6 empty pop word", 0, 0);
        check("R6 empty pop level", 32'(rx_level), 0);

        // R5 repeated start between two writes
        ev_addr(ME, 1'b0); ev_byte(8'h11); ev_byte(8'h22);
        ev_addr(ME, 1'b0); ev_byte(8'h33); ev_stop();
        check("R5 level", 32'(rx_level), 5);
        pop_chk("R5 first start", 1, 8'h54);
        pop_chk("R5 data", 2, 8'h11);
        pop_chk("R5 close", 3, 8'h22);
        pop_chk("R5 second start", 1, 8'h54);
        pop_chk("R5 second close", 3, 8'h33);

        // R10/R11 write then read
        ev_addr(ME, 1'b0); ev_byte(8'h05); ev_addr(ME, 1'b1);
        check("R10 read request", flag_word, (32'h1 << 24) | (32'h1 << 21));
        check("R10 level", 32'(rx_level), 2);
        ev_txe();
        check("R11 underrun", 32'(flag_word[22]), 1);
        ev_stop();
        check("R11 busy", flag_word, 32'h1F << 21 & ~(32'h3 << 25));
        clear(32'hFFFF_FFFF);
        check("R8 w1c", flag_word, 0);
        pop_chk("R10 start", 1, 8'h54);
        pop_chk("R10 close", 3, 8'h05);

        // R10/R11 plain read and stray transmit-empty
        ev_addr(ME, 1'b1); ev_txe(); ev_stop();
        check("R10 plain read", flag_word, (32'h1 << 23) | (32'h1 << 22));
        clear(32'hFFFF_FFFF);
        ev_txe();
        check("R11 idle txe ignored", flag_word, 0);
        ev_addr(OTHER, 1'b1); ev_txe(); ev_stop();
        check("R11 foreign read ignored", flag_word, 0);

        // R9 threshold
        rx_thld = CW'(4);
        ev_addr(ME, 1'b0); ev_byte(8'hA0); ev_byte(8'hA1); ev_byte(8'hA2);
        check("R9 below", 32'(flag_word[25]), 0);
        ev_byte(8'hA3);
        check("R9 reached", 32'(flag_word[25]), 1);
        clear(32'h1 << 25);
        check("R9 held at level", 32'(flag_word[25]), 1);
        ev_stop();
        pop_chk("R9 pop", 1, 8'h54);
        pop_chk("R9 pop", 2, 8'hA0);
        clear(32'h1 << 25);
        check("R9 cleared below", 32'(flag_word[25]), 0);
        flush();
        rx_thld = '0;
        clear(32'hFFFF_FFFF);

        // R7 overflow
        ev_addr(ME, 1'b0);
        for (int i = 0; i < 70; i++) ev_byte(8'(i));
        ev_stop();
        check("R7 level capped", 32'(rx_level), DEPTH);
        check("R7 full flag", 32'(flag_word[26]), 1);
        clear(32'h1 << 26);
        check("R7 full held", 32'(flag_word[26]), 1);
        pop_chk("R7 head", 1, 8'h54);
        clear(32'h1 << 26);
        check("R7 full cleared", 32'(flag_word[26]), 0);
        for (int i = 0; i < DEPTH - 1; i++) pop_chk("R7 order", 2, i);
        check("R7 drained", 32'(rx_level), 0);

        // R12 flush against a push in the same cycle
        ev_addr(ME, 1'b0); ev_byte(8'h01); ev_byte(8'h02);
        check("R12 before", 32'(rx_level), 2);
        rx_flush = 1'b1; eng_byte_vld = 1'b1; eng_byte = 8'h03;
        @(negedge clk);
        rx_flush = 1'b0; eng_byte_vld = 1'b0;
        check("R12 flushed", 32'(rx_level), 0);
        ev_stop();
        pop_chk("R12 held byte kept", 3, 8'h03);
        check("R12 end", 32'(rx_level), 0);

        done = 1'b1;
        finish_run();
    end

endmodule